// File: doc/BRIEF.md
# Patterned Line Drawing Engine

The engine walks a straight line between two programmed endpoints on a bit-plane frame buffer. The frame buffer stores one bit per pixel per plane, so eight horizontally adjacent pixels share one byte address. For every byte the line touches, the engine sends one request to the downstream raster unit. A request carries the byte address and an 8-bit write mask that selects the pixels to paint in that byte. The per-plane read-modify-write happens downstream and is not part of this block.

A controller sets the coordinates, a 16-bit dash pattern and a two-byte address offset, then pulses the start input. The engine first computes a 15-bit fixed-point slope with a serial divider. It then steps one pixel per clock along the major axis. Each pixel is gated by the top bit of a rotating dash pattern. Drawn pixels that fall into the same byte are merged into a single mask. When the walk ends, the busy output stays high for a hold time proportional to the number of requests issued. This models the time the raster unit needs to process them.

Top module: `line_draw_engine`

## Requirements
- R1: After reset, busy_o and req_valid_o are 0.
- R2: start_i is accepted only while busy_o is 0. A pulse during a run changes neither the requests nor the busy length of that run.
- R3: A pixel at (x, y) maps to byte address (y*SCR_W/8 + x/8 + offset) modulo 2^ADDR_W. Within that byte it maps to mask bit 8'h80 >> (x mod 8).
- R4: The offset is {offs_hi_i[5:0], offs_lo_i[7:0], 1'b0}. Bits 7:6 of offs_hi_i have no effect on the addresses.
- R5: The dash pattern is used from bit 15 downward, one bit per pixel step. A pixel is painted only when the current bit 15 is 1. The pattern rotates left by one on every step, painted or not.
- R6: The major axis is X when |dx| >= |dy|, and Y otherwise. The slope is floor(minor*32768/major). On each step a fraction accumulator adds the slope. When the sum exceeds 16384, the minor coordinate moves one toward the end point and 32768 is subtracted.
- R7: Painted pixels with the same byte address on consecutive steps are OR-merged. The merged request is issued when the address changes or the line ends. A request with an all-zero mask is never issued.
- R8: A horizontal run covering a whole aligned byte with a solid pattern yields a single request with mask 8'hFF.
- R9: For a line with major length M that issues N requests, busy_o stays high for exactly 19 + M + BUSY_PER_REQ*N cycles, and every request lies inside that window.
- R10: A line may run in any direction. The first pixel is the start point, the last pixel is the end point, and M+1 pixel steps are taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start strobe |
| x_start_i | input | 10 | Start X |
| y_start_i | input | 9 | Start Y |
| x_end_i | input | 10 | End X |
| y_end_i | input | 9 | End Y |
| style_i | input | 16 | Dash pattern |
| offs_hi_i | input | 8 | Offset high byte (bits 5:0 used) |
| offs_lo_i | input | 8 | Offset low byte |
| req_valid_o | output | 1 | Request strobe |
| req_addr_o | output | ADDR_W | Request byte address |
| req_mask_o | output | 8 | Request pixel mask |
| busy_o | output | 1 | Run in progress or hold time pending |

## Verification
The assertions assume that start_i is the only event that launches work, and that BUSY_PER_REQ is at least 1. With that setting, every request issued in the final flush falls inside the hold window. They also assume that the inputs are sampled only at the accepting edge, so later changes to them are irrelevant. The stimulus changes inputs only on the falling edge. It issues every new start only after busy_o has dropped, except in the single run that deliberately pulses start_i mid-run with different endpoints to show the pulse is ignored. All endpoints stay within the 10-bit and 9-bit coordinate ranges that the port widths impose.

// File: rtl/line_pkg.sv
package line_pkg;
  localparam int XW        = 10;
  localparam int YW        = 9;
  localparam int FRAC_W    = 15;
  localparam int SLOPE_W   = FRAC_W + 1;
  localparam int ACC_W     = FRAC_W + 3;
  localparam int OFF_W     = 15;
  localparam int HALF_STEP = 1 << (FRAC_W - 1);
  localparam int FULL_STEP = 1 << FRAC_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_DIV,
    ST_DRAW,
    ST_FLUSH,
    ST_HOLD
  } ln_state_e;
endpackage

// File: rtl/line_slope_div.sv
module line_slope_div #(
  parameter int NW = 10,
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [NW-1:0] minor_i,
  input  logic [NW-1:0] major_i,
  output logic [QW-1:0] quot_o
);
  logic [NW-1:0] rem_q, rem_d;
  logic [NW-1:0] den_q, den_d;
  logic [QW-1:0] dvd_q, dvd_d;
  logic [QW-1:0] quot_q, quot_d;
  logic [NW:0]   trial;
  logic          ge;

  // restoring division of (minor << (QW-1)) by major, one quotient bit per step
  always_comb begin
    trial  = {rem_q, dvd_q[QW-1]};
    ge     = (trial >= {1'b0, den_q});
    rem_d  = rem_q;
    den_d  = den_q;
    dvd_d  = dvd_q;
    quot_d = quot_q;
    if (load_i) begin
      rem_d  = minor_i >> 1;
      den_d  = major_i;
      dvd_d  = {minor_i[0], {(QW-1){1'b0}}};
      quot_d = '0;
    end else if (step_i) begin
      rem_d  = ge ? NW'(trial - {1'b0, den_q}) : trial[NW-1:0];
      dvd_d  = {dvd_q[QW-2:0], 1'b0};
      quot_d = {quot_q[QW-2:0], ge};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      dvd_q  <= '0;
      quot_q <= '0;
    end else if (load_i || step_i) begin
      rem_q  <= rem_d;
      den_q  <= den_d;
      dvd_q  <= dvd_d;
      quot_q <= quot_d;
    end
  end

  assign quot_o = quot_q;

  // R6: the partial remainder stays below the divisor, else the quotient overflows
  p_rem_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && den_q != '0) |-> (rem_q < den_q));
endmodule

// File: rtl/line_addr_map.sv
module line_addr_map #(
  parameter int ADDR_W    = 15,
  parameter int ROW_BYTES = 80,
  parameter int XW        = 10,
  parameter int YW        = 9,
  parameter int OFF_W     = 15
) (
  input  logic [XW-1:0]     x_i,
  input  logic [YW-1:0]     y_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        bit_o
);
  // arithmetic kept to ADDR_W bits gives the modulo wrap for free
  always_comb begin
    addr_o = ADDR_W'(y_i) * ADDR_W'(ROW_BYTES)
           + ADDR_W'(x_i >> 3)
           + ADDR_W'(off_i);
    bit_o  = 8'h80 >> x_i[2:0];
  end
endmodule

// File: rtl/line_byte_merge.sv
module line_byte_merge #(
  parameter int ADDR_W = 15,
  parameter int REQ_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              pix_vld_i,
  input  logic [ADDR_W-1:0] pix_addr_i,
  input  logic [7:0]        pix_bits_i,
  input  logic              fin_i,
  output logic              req_vld_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [7:0]        req_mask_o,
  output logic              pend_o,
  output logic [REQ_W-1:0]  nreq_o
);
  logic [ADDR_W-1:0] cur_addr_q, cur_addr_d;
  logic [7:0]        cur_mask_q, cur_mask_d;
  logic [REQ_W-1:0]  nreq_q, nreq_d;
  logic              emit;
  logic              req_vld_q;
  logic [ADDR_W-1:0] req_addr_q;
  logic [7:0]        req_mask_q;

  assign pend_o = (cur_mask_q != 8'h00);

  always_comb begin
    emit       = 1'b0;
    cur_addr_d = cur_addr_q;
    cur_mask_d = cur_mask_q;
    nreq_d     = nreq_q;
    if (clr_i) begin
      cur_addr_d = '0;
      cur_mask_d = 8'h00;
      nreq_d     = '0;
    end else if (pix_vld_i) begin
      if (pix_addr_i != cur_addr_q) begin
        emit       = pend_o;
        cur_addr_d = pix_addr_i;
        cur_mask_d = pix_bits_i;
      end else begin
        cur_mask_d = cur_mask_q | pix_bits_i;
      end
    end else if (fin_i) begin
      emit       = pend_o;
      cur_mask_d = 8'h00;
    end
    if (emit) nreq_d = nreq_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr_q <= '0;
      cur_mask_q <= 8'h00;
      nreq_q     <= '0;
      req_vld_q  <= 1'b0;
      req_addr_q <= '0;
      req_mask_q <= 8'h00;
    end else begin
      cur_addr_q <= cur_addr_d;
      cur_mask_q <= cur_mask_d;
      nreq_q     <= nreq_d;
      req_vld_q  <= emit;
      if (emit) begin
        req_addr_q <= cur_addr_q;
        req_mask_q <= cur_mask_q;
      end
    end
  end

  assign req_vld_o  = req_vld_q;
  assign req_addr_o = req_addr_q;
  assign req_mask_o = req_mask_q;
  assign nreq_o     = nreq_q;

  // R7: an issued request always paints at least one pixel
  p_mask_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld_o |-> (req_mask_o != 8'h00));
  // R7: a pending merged byte is issued by the end-of-line flush
  p_flush_emits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_i && !clr_i && !pix_vld_i && pend_o) |=> req_vld_o);
endmodule

// File: rtl/line_draw_engine.sv
module line_draw_engine
  import line_pkg::*;
#(
  parameter int SCR_W        = 640,
  parameter int ADDR_W       = 15,
  parameter int BUSY_PER_REQ = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [9:0]        x_start_i,
  input  logic [8:0]        y_start_i,
  input  logic [9:0]        x_end_i,
  input  logic [8:0]        y_end_i,
  input  logic [15:0]       style_i,
  input  logic [7:0]        offs_hi_i,
  input  logic [7:0]        offs_lo_i,
  output logic              req_valid_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [7:0]        req_mask_o,
  output logic              busy_o
);
  localparam int ROW_BYTES = SCR_W / 8;
  localparam int REQ_W     = XW + 1;
  localparam int HOLD_W    = $clog2((1 << XW) * BUSY_PER_REQ + 1);
  localparam int DC_W      = $clog2(SLOPE_W);
  localparam logic signed [ACC_W-1:0] HALF_S = ACC_W'(HALF_STEP);
  localparam logic signed [ACC_W-1:0] FULL_S = ACC_W'(FULL_STEP);

  ln_state_e         state_q, state_d;
  logic [XW-1:0]     x_q, x_d, xe_q;
  logic [YW-1:0]     y_q, y_d, ye_q;
  logic [15:0]       pat_q, pat_d;
  logic [OFF_W-1:0]  off_q;
  logic              xmaj_q, xneg_q, yneg_q;
  logic [XW-1:0]     cnt_q, cnt_d;
  logic [DC_W-1:0]   divc_q, divc_d;
  logic signed [ACC_W-1:0] acc_q, acc_d, sum;
  logic [HOLD_W-1:0] hold_q, hold_d, hold_load;

  logic              lat_en, setup_en, div_step, step_en, pix_vld, fin;
  logic [XW-1:0]     dxa, dya, maj, mnr;
  logic              xmaj_c, mstep;
  logic [SLOPE_W-1:0] slope;
  logic [ADDR_W-1:0] pix_addr;
  logic [7:0]        pix_bit, pix_bits;
  logic              pend;
  logic [REQ_W-1:0]  nreq, tot;

  // setup geometry from the latched endpoints
  always_comb begin
    dxa    = (xe_q >= x_q) ? (xe_q - x_q) : (x_q - xe_q);
    dya    = XW'((ye_q >= y_q) ? (ye_q - y_q) : (y_q - ye_q));
    xmaj_c = (dxa >= dya);
    maj    = xmaj_c ? dxa : dya;
    mnr    = xmaj_c ? dya : dxa;
  end

  line_slope_div #(.NW(XW), .QW(SLOPE_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (setup_en),
    .step_i  (div_step),
    .minor_i (mnr),
    .major_i (maj),
    .quot_o  (slope)
  );

  line_addr_map #(
    .ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES), .XW(XW), .YW(YW), .OFF_W(OFF_W)
  ) u_map (
    .x_i    (x_q),
    .y_i    (y_q),
    .off_i  (off_q),
    .addr_o (pix_addr),
    .bit_o  (pix_bit)
  );

  assign pix_bits = pat_q[15] ? pix_bit : 8'h00;

  line_byte_merge #(.ADDR_W(ADDR_W), .REQ_W(REQ_W)) u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (setup_en),
    .pix_vld_i  (pix_vld),
    .pix_addr_i (pix_addr),
    .pix_bits_i (pix_bits),
    .fin_i      (fin),
    .req_vld_o  (req_valid_o),
    .req_addr_o (req_addr_o),
    .req_mask_o (req_mask_o),
    .pend_o     (pend),
    .nreq_o     (nreq)
  );

  assign tot       = nreq + REQ_W'(pend);
  assign hold_load = HOLD_W'(tot) * HOLD_W'(BUSY_PER_REQ);

  // sequencing
  always_comb begin
    state_d  = state_q;
    lat_en   = 1'b0;
    setup_en = 1'b0;
    div_step = 1'b0;
    step_en  = 1'b0;
    pix_vld  = 1'b0;
    fin      = 1'b0;
    divc_d   = divc_q;
    cnt_d    = cnt_q;
    hold_d   = hold_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        lat_en  = 1'b1;
        state_d = ST_SETUP;
      end
      ST_SETUP: begin
        setup_en = 1'b1;
        divc_d   = DC_W'(SLOPE_W - 1);
        cnt_d    = maj;
        state_d  = ST_DIV;
      end
      ST_DIV: begin
        div_step = 1'b1;
        if (divc_q == '0) state_d = ST_DRAW;
        else divc_d = divc_q - 1'b1;
      end
      ST_DRAW: begin
        pix_vld = 1'b1;
        step_en = 1'b1;
        if (cnt_q == '0) state_d = ST_FLUSH;
        else cnt_d = cnt_q - 1'b1;
      end
      ST_FLUSH: begin
        fin     = 1'b1;
        hold_d  = hold_load;
        state_d = (hold_load == '0) ? ST_IDLE : ST_HOLD;
      end
      ST_HOLD: begin
        if (hold_q <= HOLD_W'(1)) begin
          hold_d  = '0;
          state_d = ST_IDLE;
        end else begin
          hold_d = hold_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // fixed-point stepper and pattern rotation
  always_comb begin
    sum   = acc_q + $signed({{(ACC_W-SLOPE_W){1'b0}}, slope});
    mstep = (sum > HALF_S);
    x_d   = x_q;
    y_d   = y_q;
    acc_d = acc_q;
    pat_d = pat_q;
    if (lat_en) begin
      x_d   = x_start_i;
      y_d   = y_start_i;
      pat_d = style_i;
    end else if (setup_en) begin
      acc_d = '0;
    end else if (step_en) begin
      if (xmaj_q || mstep) x_d = xneg_q ? (x_q - 1'b1) : (x_q + 1'b1);
      if (!xmaj_q || mstep) y_d = yneg_q ? (y_q - 1'b1) : (y_q + 1'b1);
      acc_d = mstep ? (sum - FULL_S) : sum;
      pat_d = {pat_q[14:0], pat_q[15]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      xe_q    <= '0;
      ye_q    <= '0;
      pat_q   <= '0;
      off_q   <= '0;
      xmaj_q  <= 1'b0;
      xneg_q  <= 1'b0;
      yneg_q  <= 1'b0;
      cnt_q   <= '0;
      divc_q  <= '0;
      acc_q   <= '0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      x_q     <= x_d;
      y_q     <= y_d;
      pat_q   <= pat_d;
      acc_q   <= acc_d;
      cnt_q   <= cnt_d;
      divc_q  <= divc_d;
      hold_q  <= hold_d;
      if (lat_en) begin
        xe_q  <= x_end_i;
        ye_q  <= y_end_i;
        off_q <= {offs_hi_i[5:0], offs_lo_i, 1'b0};
      end
      if (setup_en) begin
        xmaj_q <= xmaj_c;
        xneg_q <= (xe_q < x_q);
        yneg_q <= (ye_q < y_q);
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  // R2: a run in progress never re-enters setup
  p_restart_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> (state_q != ST_SETUP));
  // R9: requests appear only while busy is held
  p_req_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> busy_o);
  // R9: hold window counts down one per cycle
  p_hold_countdown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && hold_q > HOLD_W'(1)) |=>
      (state_q == ST_HOLD && hold_q == $past(hold_q) - 1'b1));
  // R10: the walk takes one pixel per cycle until the step count is spent
  p_draw_runs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAW && cnt_q != '0) |=>
      (state_q == ST_DRAW && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: tb/line_draw_engine_tb_top.sv
`timescale 1ns/1ps
module line_draw_engine_tb_top;
  localparam int SCR_W  = 640;
  localparam int ADDR_W = 15;
  localparam int K      = 2;
  localparam int ROW    = SCR_W / 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i;
  logic [9:0]        x_start_i, x_end_i;
  logic [8:0]        y_start_i, y_end_i;
  logic [15:0]       style_i;
  logic [7:0]        offs_hi_i, offs_lo_i;
  logic              req_valid_o;
  logic [ADDR_W-1:0] req_addr_o;
  logic [7:0]        req_mask_o;
  logic              busy_o;

  always #2.5 clk = ~clk;

  line_draw_engine #(.SCR_W(SCR_W), .ADDR_W(ADDR_W), .BUSY_PER_REQ(K)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .x_start_i(x_start_i), .y_start_i(y_start_i),
    .x_end_i(x_end_i), .y_end_i(y_end_i), .style_i(style_i),
    .offs_hi_i(offs_hi_i), .offs_lo_i(offs_lo_i),
    .req_valid_o(req_valid_o), .req_addr_o(req_addr_o),
    .req_mask_o(req_mask_o), .busy_o(busy_o)
  );

  int    nchk = 0;
  int    nerr = 0;
  string tag  = "R1";
  logic [ADDR_W+7:0] exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: pop expected requests in issue order
  always @(negedge clk) begin
    if (rst_n === 1'b1 && req_valid_o === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, tag, "unexpected request addr/mask",
              {req_addr_o, req_mask_o}, 0);
      end else begin
        logic [ADDR_W+7:0] e;
        e = exp_q.pop_front();
        check({req_addr_o, req_mask_o} == e, tag, "request addr/mask",
              {req_addr_o, req_mask_o}, e);
      end
    end
  end

  // driver: model the line from the requirements, push expected, run and time busy
  task automatic run_line(input int x0, input int y0, input int x1, input int y1,
                          input logic [15:0] pat, input logic [7:0] ohi,
                          input logic [7:0] olo, input bit again, input string t);
    int dx, dy, adx, ady, sx, sy, maj, mnr, slope, acc, x, y, off, n, cyc, exp_busy;
    bit xmaj;
    logic [15:0] p;
    int cur_addr;
    logic [7:0] cur_mask, b;
    tag = t;
    dx = x1 - x0; dy = y1 - y0;
    adx = (dx < 0) ? -dx : dx; ady = (dy < 0) ? -dy : dy;
    sx = (dx < 0) ? -1 : 1;    sy = (dy < 0) ? -1 : 1;
    xmaj = (adx >= ady);                                   // R6 axis choice
    maj = xmaj ? adx : ady; mnr = xmaj ? ady : adx;
    slope = (maj == 0) ? 0 : (mnr * 32768) / maj;
    off = ((ohi & 8'h3F) << 9) | (olo << 1);               // R4
    acc = 0; x = x0; y = y0; p = pat; n = 0;
    cur_addr = 0; cur_mask = 8'h00;
    for (int i = 0; i <= maj; i++) begin
      int a;
      a = (y * ROW + x / 8 + off) % (1 << ADDR_W);         // R3
      b = p[15] ? (8'h80 >> (x % 8)) : 8'h00;              // R5
      if (a != cur_addr) begin                             // R7
        if (cur_mask != 8'h00) begin exp_q.push_back({ADDR_W'(cur_addr), cur_mask}); n++; end
        cur_addr = a; cur_mask = b;
      end else begin
        cur_mask = cur_mask | b;
      end
      p = {p[14:0], p[15]};
      acc = acc + slope;
      if (xmaj) x = x + sx; else y = y + sy;
      if (acc > 16384) begin
        if (xmaj) y = y + sy; else x = x + sx;
        acc = acc - 32768;
      end
    end
    if (cur_mask != 8'h00) begin exp_q.push_back({ADDR_W'(cur_addr), cur_mask}); n++; end
    exp_busy = 19 + maj + K * n;                           // R9

    x_start_i = 10'(x0); y_start_i = 9'(y0);
    x_end_i = 10'(x1);   y_end_i = 9'(y1);
    style_i = pat; offs_hi_i = ohi; offs_lo_i = olo;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    while (busy_o === 1'b1 && cyc < 30000) begin
      cyc++;
      if (again && cyc == 5) begin                         // R2 restart attempt
        start_i = 1'b1; x_start_i = 10'd0; y_start_i = 9'd0;
        x_end_i = 10'd1023; y_end_i = 9'd511; style_i = 16'hFFFF;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check(cyc == exp_busy, {t, " R9"}, "busy length", cyc, exp_busy);
    check(exp_q.size() == 0, {t, " R7"}, "requests missing", exp_q.size(), 0);
    exp_q.delete();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0;
    x_start_i = '0; y_start_i = '0; x_end_i = '0; y_end_i = '0;
    style_i = '0; offs_hi_i = '0; offs_lo_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o === 1'b0, "R1", "busy after reset", busy_o, 0);
    check(req_valid_o === 1'b0, "R1", "req_valid after reset", req_valid_o, 0);

    run_line(0, 0, 15, 0, 16'hFFFF, 8'h00, 8'h00, 0, "R8 full bytes");
    run_line(3, 2, 12, 2, 16'hFFFF, 8'hC1, 8'h05, 0, "R3 R4 partial bytes offset");
    run_line(0, 4, 15, 4, 16'hAAAA, 8'h00, 8'h00, 0, "R5 alternate dash");
    run_line(0, 6, 17, 6, 16'h8001, 8'h00, 8'h00, 0, "R5 sparse dash");
    run_line(2, 9, 40, 9, 16'h0000, 8'h00, 8'h00, 0, "R5 R7 blank pattern");
    run_line(15, 7, 0, 7, 16'hFFFF, 8'h00, 8'h00, 0, "R10 right to left");
    run_line(9, 20, 9, 10, 16'hF0F0, 8'h00, 8'h10, 0, "R10 vertical upward");
    run_line(0, 0, 4, 1, 16'hFFFF, 8'h00, 8'h00, 0, "R6 R7 shallow");
    run_line(5, 5, 8, 30, 16'hFFFF, 8'h00, 8'h00, 0, "R6 steep");
    run_line(10, 10, 2, 18, 16'hFFFF, 8'h00, 8'h00, 0, "R6 diagonal");
    run_line(100, 37, 733, 402, 16'hF3C7, 8'h12, 8'h34, 0, "R6 long general");
    run_line(50, 50, 50, 50, 16'hFFFF, 8'h00, 8'h00, 0, "R10 single point");
    run_line(20, 30, 60, 35, 16'hFFFF, 8'h00, 8'h00, 1, "R2 start while busy");
    run_line(1000, 500, 1010, 500, 16'hFFFF, 8'h3F, 8'hFF, 0, "R3 address wrap");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog %s: actual hang expected completion", tag);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule